// File: doc/BRIEF.md
# DDR3 Write-Leveling Sweep Controller

This block drives the write-leveling search of a DDR3 interface, one byte lane after another. After a start request it raises the leveling-mode enable and waits for the memory to settle. It then selects each lane with a one-hot select and clears that lane's DQ and DQS output delays. It fires leveling strobes and reads back the single feedback bit that the PHY returns, stepping both delays together until it finds where the feedback rises from zero to one.

A lane that already reads one at zero delay sits more than one bit time late. The controller marks it as high-skew, walks it out of that zone first, and only then looks for the rising edge. Every search gives up at a fixed delay ceiling, and any lane that reaches the ceiling fails the whole run. When every lane is found, the controller works out a read-bitslip threshold: half of the smallest delay among the high-skew lanes, rounded down. It then sends a burst of bitslip pulses to each lane whose delay lies above that threshold. Done, pass and the per-lane results stay unchanged until the next start.

Top module: `wlvl_sweep_ctrl`

## Requirements
- R1: Lanes are searched in ascending order, lane 0 first. During a lane's search `lane_sel_o` is one-hot with bit n set for lane n, and it is zero outside lane activity. Each lane gets exactly one `dly_rst_o` pulse at the start of its search.
- R2: Every search step pulses `dly_inc_o` for one cycle, pulses `strobe_o` in the next cycle, and samples `fb_i` SETTLE_CYC cycles later. `dly_inc_o` and `dly_rst_o` are never high together.
- R3: If the first sample after a lane's reset is 1, the lane's `lane_hiskew_o` bit is set. Its delay is then stepped until the feedback reads 0. Otherwise the bit is cleared.
- R4: After the zero zone is reached, the delay is stepped until the feedback reads 1. The delay count at that sample is stored as the lane's delay, in `lane_dly_o[n*DW +: DW]`.
- R5: Both search phases stop when the count reaches MAX_DLY (32). That lane's stored delay is then MAX_DLY and `pass_o` ends at 0. A lane found at 31 still passes.
- R6: On a passing run the threshold is floor(min delay over high-skew lanes / 2). Each lane with a delay strictly greater than the threshold gets one bitslip. If no lane is high-skew, no bitslip is issued.
- R7: A bitslip is BS_PULSES (3) consecutive `bitslip_o` cycles with the target lane selected and `lvl_en_o` low. A failing run issues no bitslip.
- R8: `lvl_en_o` rises at start and stays high until after the last lane. At least ENABLE_WAIT cycles pass before the first strobe. Strobes occur only while `lvl_en_o` is high, and `lvl_en_o` is low once `done_o` is set.
- R9: `done_o`, `pass_o`, `lane_dly_o` and `lane_hiskew_o` hold their values until the next `start_i`. A start clears `done_o` in the following cycle.
- R10: After reset, `done_o`, `pass_o`, `lvl_en_o`, `lane_sel_o`, `strobe_o`, `dly_inc_o`, `dly_rst_o` and `bitslip_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a leveling run (taken only when idle) |
| fb_i | input | 1 | Leveling feedback bit of the selected lane |
| done_o | output | 1 | Run finished; held until next start |
| pass_o | output | 1 | All lanes found below the ceiling |
| lvl_en_o | output | 1 | Leveling-mode enable toward the mode-register logic |
| lane_sel_o | output | LANES | One-hot lane select |
| dly_rst_o | output | 1 | Clear DQ and DQS delays of the selected lane |
| dly_inc_o | output | 1 | Step DQ and DQS delays of the selected lane |
| strobe_o | output | 1 | Leveling strobe pulse |
| bitslip_o | output | 1 | Read bitslip pulse to the selected lane |
| lane_dly_o | output | LANES*DW | Found delay per lane, lane n at bits n*DW +: DW |
| lane_hiskew_o | output | LANES | High-skew flag per lane |

## Verification
The assertions assume that `fb_i` is a function of the selected lane's current delay and that it is stable from the strobe through the sample. They also assume that `start_i` is only pulsed while the block is idle or done. The bench models each lane as a feedback window: a high-skew zone of ones ending at one delay, then zeros, then ones again from a rising-edge delay. It updates its modelled delay only on the `dly_rst_o` and `dly_inc_o` pulses, so the feedback always follows the delay the block has set. Windows are chosen to cover low-skew, high-skew, threshold-equal, ceiling-minus-one and ceiling cases.

// File: rtl/wlvl_pkg.sv
package wlvl_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_EN_WAIT,
      ST_LANE_RST,
      ST_STROBE,
      ST_SETTLE,
      ST_SAMPLE,
      ST_INC,
      ST_LANE_END,
      ST_LVL_OFF,
      ST_BS_SCAN,
      ST_BS_PULSE
   } wlvl_state_t;

endpackage

// File: rtl/wlvl_timer.sv
module wlvl_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [TW-1:0] load_val_i,
   output logic          zero_o
);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= load_val_i;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

   // R2
   timer_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/wlvl_slip_thr.sv
module wlvl_slip_thr #(
   parameter int LANES = 4,
   parameter int DW    = 6
) (
   input  logic [LANES*DW-1:0] dly_flat_i,
   input  logic [LANES-1:0]    hiskew_i,
   output logic                any_o,
   output logic [DW-1:0]       thr_o
);

   logic [DW-1:0] dly_arr [LANES];
   logic [DW-1:0] min_v;

   for (genvar g = 0; g < LANES; g++) begin : g_unpack
      assign dly_arr[g] = dly_flat_i[g*DW +: DW];
   end

   always_comb begin
      min_v = '1;
      for (int i = 0; i < LANES; i++) begin
         if (hiskew_i[i] && (dly_arr[i] < min_v))
            min_v = dly_arr[i];
      end
   end

   assign any_o = |hiskew_i;
   assign thr_o = min_v >> 1;

endmodule

// File: rtl/wlvl_sweep_ctrl.sv
module wlvl_sweep_ctrl
   import wlvl_pkg::*;
#(
   parameter int LANES       = 4,
   parameter int MAX_DLY     = 32,
   parameter int SETTLE_CYC  = 10,
   parameter int ENABLE_WAIT = 100,
   parameter int BS_PULSES   = 3,
   localparam int DW  = $clog2(MAX_DLY + 1),
   localparam int LIW = (LANES > 1) ? $clog2(LANES) : 1,
   localparam int TMX = (ENABLE_WAIT > SETTLE_CYC) ? ENABLE_WAIT : SETTLE_CYC,
   localparam int TW  = $clog2(TMX + 1),
   localparam int BW  = $clog2(BS_PULSES + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                fb_i,
   output logic                done_o,
   output logic                pass_o,
   output logic                lvl_en_o,
   output logic [LANES-1:0]    lane_sel_o,
   output logic                dly_rst_o,
   output logic                dly_inc_o,
   output logic                strobe_o,
   output logic                bitslip_o,
   output logic [LANES*DW-1:0] lane_dly_o,
   output logic [LANES-1:0]    lane_hiskew_o
);

   if (LANES < 1 || MAX_DLY < 2 || BS_PULSES < 1 || SETTLE_CYC < 0 || ENABLE_WAIT < 1)
   begin : g_param_bad
      $error("wlvl_sweep_ctrl: illegal parameter set");
   end

   localparam logic [DW-1:0]  MAX_V  = DW'(MAX_DLY);
   localparam logic [LIW-1:0] LAST_L = LIW'(LANES - 1);
   localparam logic [BW-1:0]  BS_END = BW'(BS_PULSES - 1);

   wlvl_state_t    state_q;
   logic [LIW-1:0] lane_q;
   logic [DW-1:0]  cnt_q;
   logic           seek_q;
   logic           first_q;
   logic           hs_cur_q;
   logic           fail_q;
   logic           done_q;
   logic           pass_q;
   logic           lvl_en_q;
   logic [BW-1:0]  bs_cnt_q;
   logic [DW-1:0]  dly_q [LANES];
   logic [LANES-1:0] hs_q;

   logic          tmr_load;
   logic [TW-1:0] tmr_val;
   logic          tmr_zero;
   logic          slip_any;
   logic [DW-1:0] slip_thr;
   logic          seek_now;
   logic          found;
   logic [DW-1:0] cnt_nxt;
   logic          last_lane;
   logic          sel_act;

   // ---------------- wait timer ----------------
   assign tmr_load = ((state_q == ST_IDLE) && start_i) || (state_q == ST_STROBE);
   assign tmr_val  = (state_q == ST_IDLE) ? TW'(ENABLE_WAIT) : TW'(SETTLE_CYC);

   wlvl_timer #(.TW(TW)) i_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .zero_o     (tmr_zero)
   );

   // ---------------- bitslip threshold ----------------
   wlvl_slip_thr #(.LANES(LANES), .DW(DW)) i_slip_thr (
      .dly_flat_i (lane_dly_o),
      .hiskew_i   (hs_q),
      .any_o      (slip_any),
      .thr_o      (slip_thr)
   );

   // ---------------- search step decision ----------------
   always_comb begin
      seek_now  = !fb_i || (seek_q && !first_q);
      found     = seek_now && fb_i;
      cnt_nxt   = cnt_q + 1'b1;
      last_lane = (lane_q == LAST_L);
   end

   // ---------------- sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         lane_q   <= '0;
         cnt_q    <= '0;
         seek_q   <= 1'b0;
         first_q  <= 1'b0;
         hs_cur_q <= 1'b0;
         fail_q   <= 1'b0;
         done_q   <= 1'b0;
         pass_q   <= 1'b0;
         lvl_en_q <= 1'b0;
         bs_cnt_q <= '0;
         hs_q     <= '0;
         for (int i = 0; i < LANES; i++) dly_q[i] <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  done_q   <= 1'b0;
                  pass_q   <= 1'b0;
                  fail_q   <= 1'b0;
                  lvl_en_q <= 1'b1;
                  lane_q   <= '0;
                  state_q  <= ST_EN_WAIT;
               end
            end
            ST_EN_WAIT: begin
               if (tmr_zero) state_q <= ST_LANE_RST;
            end
            ST_LANE_RST: begin
               cnt_q    <= '0;
               seek_q   <= 1'b0;
               first_q  <= 1'b1;
               hs_cur_q <= 1'b0;
               state_q  <= ST_STROBE;
            end
            ST_STROBE: begin
               state_q <= ST_SETTLE;
            end
            ST_SETTLE: begin
               if (tmr_zero) state_q <= ST_SAMPLE;
            end
            ST_SAMPLE: begin
               first_q <= 1'b0;
               seek_q  <= seek_now;
               if (first_q) hs_cur_q <= fb_i;
               if (found) begin
                  state_q <= ST_LANE_END;
               end else begin
                  cnt_q <= cnt_nxt;
                  if (cnt_nxt >= MAX_V) state_q <= ST_LANE_END;
                  else                  state_q <= ST_INC;
               end
            end
            ST_INC: begin
               state_q <= ST_STROBE;
            end
            ST_LANE_END: begin
               dly_q[lane_q] <= cnt_q;
               hs_q[lane_q]  <= hs_cur_q;
               if (cnt_q >= MAX_V) fail_q <= 1'b1;
               if (last_lane) begin
                  state_q <= ST_LVL_OFF;
               end else begin
                  lane_q  <= lane_q + 1'b1;
                  state_q <= ST_LANE_RST;
               end
            end
            ST_LVL_OFF: begin
               lvl_en_q <= 1'b0;
               lane_q   <= '0;
               if (fail_q || !slip_any) begin
                  done_q  <= 1'b1;
                  pass_q  <= !fail_q;
                  state_q <= ST_IDLE;
               end else begin
                  state_q <= ST_BS_SCAN;
               end
            end
            ST_BS_SCAN: begin
               bs_cnt_q <= '0;
               if (dly_q[lane_q] > slip_thr) begin
                  state_q <= ST_BS_PULSE;
               end else if (last_lane) begin
                  done_q  <= 1'b1;
                  pass_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  lane_q <= lane_q + 1'b1;
               end
            end
            ST_BS_PULSE: begin
               bs_cnt_q <= bs_cnt_q + 1'b1;
               if (bs_cnt_q == BS_END) begin
                  if (last_lane) begin
                     done_q  <= 1'b1;
                     pass_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     lane_q  <= lane_q + 1'b1;
                     state_q <= ST_BS_SCAN;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // ---------------- outputs ----------------
   assign sel_act = (state_q == ST_LANE_RST) || (state_q == ST_STROBE) ||
                    (state_q == ST_SETTLE)   || (state_q == ST_SAMPLE) ||
                    (state_q == ST_INC)      || (state_q == ST_LANE_END) ||
                    (state_q == ST_BS_PULSE);

   for (genvar g = 0; g < LANES; g++) begin : g_lane_out
      assign lane_sel_o[g]            = sel_act && (lane_q == LIW'(g));
      assign lane_dly_o[g*DW +: DW]   = dly_q[g];
      assign lane_hiskew_o[g]         = hs_q[g];
   end

   assign done_o    = done_q;
   assign pass_o    = pass_q;
   assign lvl_en_o  = lvl_en_q;
   assign dly_rst_o = (state_q == ST_LANE_RST);
   assign dly_inc_o = (state_q == ST_INC);
   assign strobe_o  = (state_q == ST_STROBE);
   assign bitslip_o = (state_q == ST_BS_PULSE);

   // ---------------- assertions ----------------
   // R1
   lane_sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lane_sel_o));

   // R2
   rst_inc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(dly_rst_o && dly_inc_o));

   // R2
   inc_then_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dly_inc_o |=> strobe_o);

   // R1
   strobe_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |-> $onehot(lane_sel_o));

   // R8
   strobe_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |-> lvl_en_o);

   // R7
   bitslip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bitslip_o |-> (!lvl_en_o && $onehot(lane_sel_o)));

   // R5
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= MAX_V);

   // R9
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> (done_o && $stable(pass_o) &&
                                $stable(lane_dly_o) && $stable(lane_hiskew_o)));

   // R8
   done_en_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !lvl_en_o);

endmodule

// File: tb/test_wlvl_sweep_ctrl.sv
module test_wlvl_sweep_ctrl;

   localparam int LANES = 4;
   localparam int MAXD  = 32;
   localparam int SETL  = 10;
   localparam int ENW   = 100;
   localparam int BSP   = 3;
   localparam int DW    = $clog2(MAXD + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic fb_i = 1'b0;
   logic done_o, pass_o, lvl_en_o, dly_rst_o, dly_inc_o, strobe_o, bitslip_o;
   logic [LANES-1:0]    lane_sel_o;
   logic [LANES*DW-1:0] lane_dly_o;
   logic [LANES-1:0]    lane_hiskew_o;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   int h_w [LANES];
   int e_w [LANES];
   int mdl [LANES];
   int bs_seen [LANES];
   int rst_seen [LANES];
   int first_strobe;

   always #5 clk = ~clk;

   wlvl_sweep_ctrl #(
      .LANES(LANES), .MAX_DLY(MAXD), .SETTLE_CYC(SETL),
      .ENABLE_WAIT(ENW), .BS_PULSES(BSP)
   ) i_wlvl_sweep_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .fb_i(fb_i),
      .done_o(done_o), .pass_o(pass_o), .lvl_en_o(lvl_en_o),
      .lane_sel_o(lane_sel_o), .dly_rst_o(dly_rst_o), .dly_inc_o(dly_inc_o),
      .strobe_o(strobe_o), .bitslip_o(bitslip_o),
      .lane_dly_o(lane_dly_o), .lane_hiskew_o(lane_hiskew_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int sel_idx(input logic [LANES-1:0] s);
      for (int i = 0; i < LANES; i++) if (s[i]) return i;
      return -1;
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic run(input int h0, input int h1, input int h2, input int h3,
                      input int e0, input int e1, input int e2, input int e3,
                      input string tag);
      int  n;
      int  li;
      bit  got;
      int  exp_d [LANES];
      bit  exp_h [LANES];
      bit  exp_pass;
      bit  any_h;
      int  mn;
      int  thr;
      h_w = '{h0, h1, h2, h3};
      e_w = '{e0, e1, e2, e3};
      for (int i = 0; i < LANES; i++) begin
         mdl[i] = 99; bs_seen[i] = 0; rst_seen[i] = 0;
      end
      first_strobe = -1;
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      // R9: start clears done one cycle later
      chk({tag, " R9 done cleared by start"}, int'(done_o), 0);
      n = 1; got = 0;
      while (n < 20000 && !got) begin
         li = sel_idx(lane_sel_o);
         if (dly_rst_o && li >= 0) begin mdl[li] = 0; rst_seen[li]++; end
         if (dly_inc_o && li >= 0) mdl[li]++;
         if (strobe_o && first_strobe < 0) first_strobe = n;
         if (bitslip_o && li >= 0) bs_seen[li]++;
         if (li >= 0)
            fb_i = (mdl[li] < h_w[li]) || (mdl[li] >= e_w[li]);
         else
            fb_i = 1'b0;
         if (done_o) got = 1;
         else begin @(negedge clk); n++; end
      end
      if (!got) begin
         fails++;
         $display("FAIL %s watchdog actual=%0d expected=done", tag, n);
         return;
      end
      // expected results from the requirements
      exp_pass = 1; any_h = 0; mn = 1 << 30;
      for (int i = 0; i < LANES; i++) begin
         exp_h[i] = (h_w[i] > 0);
         if (exp_h[i] && h_w[i] >= MAXD) exp_d[i] = MAXD;
         else exp_d[i] = (e_w[i] >= MAXD) ? MAXD : e_w[i];
         if (exp_d[i] >= MAXD) exp_pass = 0;
         if (exp_h[i]) begin
            any_h = 1;
            if (exp_d[i] < mn) mn = exp_d[i];
         end
      end
      thr = mn / 2;
      chk({tag, " R5 pass"}, int'(pass_o), int'(exp_pass));
      chk({tag, " R8 lvl_en low at done"}, int'(lvl_en_o), 0);
      checks++;
      if (first_strobe < ENW) begin
         fails++;
         $display("FAIL %s R8 enable wait actual=%0d expected>=%0d", tag, first_strobe, ENW);
      end
      for (int i = 0; i < LANES; i++) begin
         chk($sformatf("%s R4 delay lane%0d", tag, i),
             int'(lane_dly_o[i*DW +: DW]), exp_d[i]);
         chk($sformatf("%s R3 hiskew lane%0d", tag, i),
             int'(lane_hiskew_o[i]), int'(exp_h[i]));
         chk($sformatf("%s R1 one reset lane%0d", tag, i), rst_seen[i], 1);
         chk($sformatf("%s R6 R7 bitslips lane%0d", tag, i), bs_seen[i],
             (exp_pass && any_h && exp_d[i] > thr) ? BSP : 0);
      end
      repeat (6) @(negedge clk);
      // R9 results held while idle
      chk({tag, " R9 done held"}, int'(done_o), 1);
      chk({tag, " R9 pass held"}, int'(pass_o), int'(exp_pass));
      chk({tag, " R9 delay held"}, int'(lane_dly_o[0 +: DW]), exp_d[0]);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 done", int'(done_o), 0);
      chk("R10 pass", int'(pass_o), 0);
      chk("R10 lvl_en", int'(lvl_en_o), 0);
      chk("R10 lane_sel", int'(lane_sel_o), 0);
      chk("R10 pulses", int'({strobe_o, dly_inc_o, dly_rst_o, bitslip_o}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R10 idle after release", int'({done_o, lvl_en_o}), 0);
      // all low-skew: no bitslip (R6)
      run(0, 0, 0, 0, 5, 9, 12, 3, "lowskew");
      // mixed high-skew: thr 5, lanes 0 and 2 slip
      run(4, 0, 7, 0, 10, 2, 20, 1, "mixed");
      // threshold edge: thr 3, delay equal to thr not slipped, 31 passes
      run(3, 0, 0, 2, 7, 3, 4, 31, "thr_edge");
      // rising edge at ceiling: fail, no bitslip
      run(0, 5, 0, 0, 6, 9, 32, 2, "ceil_fail");
      // high-skew zone never ends: capped, fail
      run(0, 40, 0, 0, 6, 50, 8, 2, "hs_stuck");
      // rerun after failure
      run(0, 0, 0, 0, 1, 30, 16, 8, "rerun");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule